// File: doc/BRIEF.md
# Dual-Strobe Byte-Lane I/O Controller for a x16 DRAM

This block is the device-side control logic of a sixteen-bit dynamic memory that has two column strobes, one per byte. It samples the active-low row strobe, both column strobes, the write enable and the output enable through a synchroniser clocked by a fast internal clock. From these it forms one internal column strobe, captures the row and column halves of the cell address from the multiplexed address pins, and decides, lane by lane, whether the shared data pins are driven with read data, sampled as write data, or left floating.

The internal column strobe becomes active when the first of the two lane strobes falls and stays active until the last of them rises. Each lane strobe still gates its own byte: the lower strobe owns data bits 7:0 and the upper strobe owns bits 15:8. The block also labels every column cycle as a read, an early write (write enable already low when the column strobe fell) or a read-modify-write (write enable fell later, during a read). The storage array sits outside this block and uses `cell_addr`, `lane_wstb` and `wdata`.

Top module: `dram_lane_ctrl`

## Requirements
- R1: The internal column strobe is active while at least one lane strobe is low. It goes active on the first lane strobe falling and inactive only when both are high, and `cycle_kind` returns to idle (0) only then.
- R2: `lane_drive[0]` can be set only while the lower strobe (`casl_n`) is low, and `lane_drive[1]` only while the upper strobe (`cash_n`) is low. Lane 0 is data bits 7:0 and lane 1 is data bits 15:8.
- R3: The address pins are captured into `cell_addr[19:10]` (the row) when `ras_n` falls.
- R4: The address pins are captured into `cell_addr[9:0]` (the column) when the internal column strobe goes active. A second lane strobe falling later in the same cycle does not capture them again.
- R5: If `we_n` is high when the column strobe goes active, the cycle is a read: `cycle_kind` = 1, and every low lane strobe drives its lane while `oe_n` is low.
- R6: While `oe_n` is high, no lane is driven.
- R7: If `we_n` is low when the column strobe goes active, the cycle is an early write: `cycle_kind` = 2. No lane is driven until the column strobe goes inactive. Each lane whose strobe falls gives a one-cycle `lane_wstb` pulse, and `wdata` then holds the data-pin value sampled with the strobe.
- R8: If `we_n` falls during a read cycle, the cycle becomes a read-modify-write: `cycle_kind` = 3. Every lane whose strobe is low gives a one-cycle `lane_wstb` pulse, with `wdata` sampled at that moment, and the lanes keep driving while `oe_n` stays low.
- R9: Once a read or read-modify-write cycle has started, the lanes keep driving while their strobes and `oe_n` stay low, even if `ras_n` rises.
- R10: A column strobe that falls while no row is open (`ras_n` high) is ignored: no write pulse, no drive, `cycle_kind` stays 0 and `cell_addr` does not change.
- R11: A change on any input pin shows on the outputs after exactly SYNC_STAGES+1 rising clock edges.
- R12: After reset, `lane_drive`, `lane_wstb`, `wdata`, `cell_addr` and `cycle_kind` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-byte column strobe, active low |
| cash_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low (high = read) |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address pins |
| dq_in | input | 2*LANE_W | Value seen on the shared data pins |
| lane_drive | output | 2 | Per-lane tristate enable for the data pins |
| lane_wstb | output | 2 | Per-lane one-cycle write strobe to the array |
| wdata | output | 2*LANE_W | Captured write data |
| cell_addr | output | 2*ADDR_W | {row, column} cell address |
| cycle_kind | output | 2 | 0 idle, 1 read, 2 early write, 3 read-modify-write |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES = 2, ADDR_W = 10 and LANE_W = 8. With these values the full 20-bit cell address is visible, and the three-edge input-to-output latency can be checked one cycle before and one cycle after the change. Write pulses are checked by a scoreboard that expects each one with its lane mask, cell address and data. The scoreboard covers byte-only and word strobes, the two write orderings, a row strobe that rises during a read, and a column strobe that arrives with no open row.

// File: rtl/dram_lane_pkg.sv
package dram_lane_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_EARLY = 2'd2,
        CYC_RMW   = 2'd3
    } cyc_kind_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
    import dram_lane_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_s,
    input  logic                cas_s,
    input  logic                we_s,
    input  logic                oe_s,
    input  logic [ADDR_W-1:0]   addr_s,
    output logic                valid_next,
    output logic                we_rise,
    output logic                drive_en,
    output logic [2*ADDR_W-1:0] cell_addr,
    output cyc_kind_e           kind
);

    typedef struct packed {
        logic              ras;
        logic              cas;
        logic              we;
        logic              oe;
        logic              valid;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.ras = ras_s;
        c_d.cas = cas_s;
        c_d.we  = we_s;
        c_d.oe  = oe_s;
        if (ras_s && !c_q.ras) begin
            c_d.row = addr_s;
        end
        if (!cas_s) begin
            c_d.valid = 1'b0;
            c_d.kind  = CYC_IDLE;
        end else if (!c_q.cas) begin
            if (c_q.ras) begin
                c_d.valid = 1'b1;
                c_d.col   = addr_s;
                c_d.kind  = we_s ? CYC_EARLY : CYC_READ;
            end else begin
                c_d.valid = 1'b0;
                c_d.kind  = CYC_IDLE;
            end
        end else if (c_q.valid && c_q.kind == CYC_READ && we_s && !c_q.we) begin
            c_d.kind = CYC_RMW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{ras: 1'b0, cas: 1'b0, we: 1'b0, oe: 1'b0, valid: 1'b0,
                     kind: CYC_IDLE, row: '0, col: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign valid_next = c_d.valid;
    assign we_rise    = we_s & ~c_q.we;
    assign drive_en   = c_q.valid & c_q.oe & (c_q.kind != CYC_EARLY);
    assign cell_addr  = {c_q.row, c_q.col};
    assign kind       = c_q.kind;

    // R4: column address holds for the whole column cycle
    assert_col_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.kind != CYC_IDLE && $past(c_q.kind) != CYC_IDLE) |-> $stable(c_q.col));

    // R10: a cycle opens only when a row was open the edge before
    assert_open_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.valid) |-> $past(c_q.ras));

    // R7: an early write never turns into a read without an idle gap
    assert_early_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.kind == CYC_EARLY) |=> (c_q.kind == CYC_EARLY || c_q.kind == CYC_IDLE));

endmodule

// File: rtl/lane_unit.sv
module lane_unit #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_s,
    input  logic              we_s,
    input  logic              we_rise,
    input  logic              valid_next,
    input  logic              drive_en,
    input  logic [LANE_W-1:0] dq_lane,
    output logic              lane_drive,
    output logic              lane_wstb,
    output logic [LANE_W-1:0] wdata_lane
);

    typedef struct packed {
        logic              act;
        logic              wstb;
        logic [LANE_W-1:0] wdata;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.act  = strobe_s;
        l_d.wstb = valid_next & strobe_s & ((~l_q.act & we_s) | we_rise);
        if (l_d.wstb) begin
            l_d.wdata = dq_lane;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign lane_drive = l_q.act & drive_en;
    assign lane_wstb  = l_q.wstb;
    assign wdata_lane = l_q.wdata;

    // R7 / R8: a write strobe lasts exactly one cycle
    assert_wstb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wstb |=> !lane_wstb);

    // R8: write data stays put between strobes
    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_wstb |-> $stable(wdata_lane));

endmodule

// File: rtl/dram_lane_ctrl.sv
module dram_lane_ctrl
    import dram_lane_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  casl_n,
    input  logic                  cash_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   dq_in,
    output logic [1:0]            lane_drive,
    output logic [1:0]            lane_wstb,
    output logic [2*LANE_W-1:0]   wdata,
    output logic [2*ADDR_W-1:0]   cell_addr,
    output logic [1:0]            cycle_kind
);

    localparam int LANES  = 2;
    localparam int DQ_W   = LANES * LANE_W;
    localparam int CTL_W  = 5;
    localparam int SYNC_W = CTL_W + ADDR_W + DQ_W;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic              ras_s, we_s, oe_s, cas_s;
    logic [LANES-1:0]  lane_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DQ_W-1:0]   dq_s;
    logic              valid_next, we_rise, drive_en;
    cyc_kind_e         kind;

    assign raw_in = {~ras_n, ~cash_n, ~casl_n, ~we_n, ~oe_n, addr, dq_in};

    strobe_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_out)
    );

    assign {ras_s, lane_s, we_s, oe_s, addr_s, dq_s} = syn_out;
    assign cas_s = |lane_s;

    cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_s     (ras_s),
        .cas_s     (cas_s),
        .we_s      (we_s),
        .oe_s      (oe_s),
        .addr_s    (addr_s),
        .valid_next(valid_next),
        .we_rise   (we_rise),
        .drive_en  (drive_en),
        .cell_addr (cell_addr),
        .kind      (kind)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_unit #(.LANE_W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_s  (lane_s[g]),
            .we_s      (we_s),
            .we_rise   (we_rise),
            .valid_next(valid_next),
            .drive_en  (drive_en),
            .dq_lane   (dq_s[g*LANE_W +: LANE_W]),
            .lane_drive(lane_drive[g]),
            .lane_wstb (lane_wstb[g]),
            .wdata_lane(wdata[g*LANE_W +: LANE_W])
        );
    end

    assign cycle_kind = kind;

    // R1: nothing is driven outside a column cycle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_IDLE) |-> (lane_drive == '0));

    // R7: an early write keeps the pins floating
    assert_early_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_EARLY) |-> (lane_drive == '0));

    // R10: write pulses only inside a column cycle
    assert_wstb_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wstb != '0) |-> (kind != CYC_IDLE && kind != CYC_READ));

endmodule

// File: tb/tb_dram_lane_ctrl.sv
module tb_dram_lane_ctrl;

    localparam int ADDR_W = 10;
    localparam int LANE_W = 8;
    localparam int DQ_W   = 2 * LANE_W;
    localparam int CELL_W = 2 * ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1;
    logic              we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   dq_in = '0;
    logic [1:0]        lane_drive, lane_wstb, cycle_kind;
    logic [DQ_W-1:0]   wdata;
    logic [CELL_W-1:0] cell_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0]        mask;
        logic [CELL_W-1:0] adr;
        logic [DQ_W-1:0]   data;
    } wr_item_t;

    wr_item_t exp_q[$];

    always #4 clk = ~clk;

    dram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .lane_drive(lane_drive), .lane_wstb(lane_wstb), .wdata(wdata),
        .cell_addr(cell_addr), .cycle_kind(cycle_kind)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic push_wr(input logic [1:0] m, input logic [CELL_W-1:0] a, input logic [DQ_W-1:0] d);
        wr_item_t it;
        it.mask = m; it.adr = a; it.data = d;
        exp_q.push_back(it);
    endtask

    // monitor: pops one expected write for every observed pulse
    always @(negedge clk) begin
        if (rst_n && lane_wstb != 2'b00) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: actual unexpected write pulse %0h expected none", lane_wstb);
            end else begin
                wr_item_t it;
                logic [DQ_W-1:0] bm;
                it = exp_q.pop_front();
                bm = {{LANE_W{it.mask[1]}}, {LANE_W{it.mask[0]}}};
                check("R7/R8 write mask", 32'(lane_wstb), 32'(it.mask));
                check("R7/R8 write address", 32'(cell_addr), 32'(it.adr));
                check("R7/R8 write data", 32'(wdata & bm), 32'(it.data & bm));
            end
        end
    end

    localparam logic [ADDR_W-1:0] ROW = 10'h155;

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12 drive", 32'(lane_drive), 0);
        check("R12 wstb", 32'(lane_wstb), 0);
        check("R12 wdata", 32'(wdata), 0);
        check("R12 addr", 32'(cell_addr), 0);
        check("R12 kind", 32'(cycle_kind), 0);
        rst_n = 1'b1;
        settle();

        // R3 row open
        addr = ROW; ras_n = 1'b0;
        settle();

        // R11 latency with a word read, R5, R4
        addr = 10'h2AA; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 not yet", 32'(lane_drive), 0);
        @(posedge clk);
        @(negedge clk);
        check("R11 after SYNC_STAGES+1", 32'(lane_drive), 3);
        check("R5 read kind", 32'(cycle_kind), 1);
        check("R3 row", 32'(cell_addr[19:10]), 32'(ROW));
        check("R4 column", 32'(cell_addr[9:0]), 32'h2AA);

        // R1 lower strobe rises, upper stays low
        addr = 10'h001; casl_n = 1'b1;
        settle();
        check("R1 still active kind", 32'(cycle_kind), 1);
        check("R2 upper only drive", 32'(lane_drive), 2);
        check("R4 column kept", 32'(cell_addr[9:0]), 32'h2AA);
        cash_n = 1'b1;
        settle();
        check("R1 idle after last rise", 32'(cycle_kind), 0);
        check("R1 no drive idle", 32'(lane_drive), 0);

        // R6 output enable high
        oe_n = 1'b1; casl_n = 1'b0; addr = 10'h010;
        settle();
        check("R6 kind read", 32'(cycle_kind), 1);
        check("R6 no drive", 32'(lane_drive), 0);
        casl_n = 1'b1;
        settle();

        // R2 lower byte read
        oe_n = 1'b0; casl_n = 1'b0; addr = 10'h020;
        settle();
        check("R2 lower only drive", 32'(lane_drive), 1);
        casl_n = 1'b1;
        settle();

        // R7 early write, upper byte
        we_n = 1'b0;
        settle();
        addr = 10'h011; dq_in = 16'hA5C3;
        push_wr(2'b10, {ROW, 10'h011}, 16'hA5C3);
        cash_n = 1'b0;
        settle();
        check("R7 early kind", 32'(cycle_kind), 2);
        check("R7 early no drive", 32'(lane_drive), 0);
        check("R7 upper data", 32'(wdata[15:8]), 32'hA5);
        cash_n = 1'b1; we_n = 1'b1;
        settle();

        // R4 second strobe does not recapture column
        addr = 10'h0F0; casl_n = 1'b0;
        settle();
        addr = 10'h333; cash_n = 1'b0;
        settle();
        check("R4 column from first strobe", 32'(cell_addr[9:0]), 32'h0F0);
        check("R2 both lanes", 32'(lane_drive), 3);
        casl_n = 1'b1; cash_n = 1'b1;
        settle();

        // R8 read-modify-write, then R9 row strobe rises
        addr = 10'h044; casl_n = 1'b0; cash_n = 1'b0;
        settle();
        dq_in = 16'h1234; we_n = 1'b0;
        push_wr(2'b11, {ROW, 10'h044}, 16'h1234);
        settle();
        check("R8 rmw kind", 32'(cycle_kind), 3);
        check("R8 keeps driving", 32'(lane_drive), 3);
        check("R8 data", 32'(wdata), 32'h1234);
        ras_n = 1'b1;
        settle();
        check("R9 drive after row strobe rises", 32'(lane_drive), 3);
        casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1;
        settle();

        // R10 column strobe with no open row
        addr = 10'h3FF; we_n = 1'b0; casl_n = 1'b0;
        settle();
        check("R10 kind idle", 32'(cycle_kind), 0);
        check("R10 no drive", 32'(lane_drive), 0);
        check("R10 addr unchanged", 32'(cell_addr), 32'({ROW, 10'h044}));
        casl_n = 1'b1; we_n = 1'b1;
        settle();

        check("R7/R8 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule